// File: doc/BRIEF.md
# Packed Signed-Byte Dot-Product Accumulator

This block is the execute stage of a custom register-register instruction. Each 32-bit source operand is split into four signed 8-bit lanes. The lanes are multiplied pairwise, the four 16-bit products are summed, and the sum is added to the value the destination register holds now. The 32-bit result is returned together with a write strobe. The register file reads and writes happen outside the block, as does any pipelining, so the unit is purely combinational.

The caller presents the instruction fields (major opcode, minor function code, extended function code and destination index) with the three operand values. The strobe is raised only for this instruction's exact encoding and a non-zero destination. The result bus always carries the computed value. The block has no valid/ready pair, because it holds no state and cannot stall: the operands and fields are sampled in the same cycle that the result is consumed, so there is nothing to apply back-pressure to.

Top module: `pdot_acc_unit`

## Requirements
- R1: `wr_en` is 1 when all of these hold: `opcode` = 7'b0101011, `funct3` = 3'b001, `funct7` = 7'b0000000 and `rd_idx` is not zero.
- R2: If any one of `opcode`, `funct3` or `funct7` differs from its encoding in R1, `wr_en` is 0.
- R3: When `rd_idx` = 0, `wr_en` is 0 even for a matching encoding.
- R4: Lane k of each source is bits [8k+7:8k] for k = 0..3. It is read as two's-complement signed, and lanes are multiplied only with the lane of the same index.
- R5: `result` = `acc_in` + (sum of the four lane products, sign-extended from its 19-bit intermediate), taken modulo 2^32.
- R6: With every lane of both sources equal to -128 (0x80808080), the products sum to +65536 and `result` = `acc_in` + 0x00010000.
- R7: The accumulation wraps at 32 bits with no saturation. For example, `acc_in` = 0x7FFFFFFF with the R6 operands gives 0x8000FFFF.
- R8: A negative product sum is sign-extended before the add. For example, 0x7F7F7F7F times 0x80808080 with `acc_in` = 0 gives 0xFFFF0200 (-65024).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Major opcode field of the instruction |
| funct3 | input | 3 | Minor function code field |
| funct7 | input | 7 | Extended function code field |
| rd_idx | input | 5 | Destination register index |
| src_a | input | 32 | First source operand, four packed signed bytes |
| src_b | input | 32 | Second source operand, four packed signed bytes |
| acc_in | input | 32 | Current destination register value |
| result | output | 32 | Accumulated value to write back |
| wr_en | output | 1 | Write strobe for the destination register |

## Verification
The bench drives all four lanes at -128, the largest positive product sum. A design with a sum path too narrow by one bit would report a negative total there. It also drives a fully negative sum into zero and into a large accumulator. A design that zero-extends the sum would leave 0x0000 in the top half instead of 0xFFFF, and a design that saturates would stick at 0x7FFFFFFF where the value should wrap. Single-lane stimulus catches swapped or misaligned byte slices and unsigned lane handling. A decode sweep flips each field alone and also tests destination zero, to catch a strobe that ignores a field or writes register zero.

// File: rtl/pdot_pkg.sv
package pdot_pkg;
  localparam int XLEN     = 32;
  localparam int LANE_W   = 8;
  localparam int LANES    = XLEN / LANE_W;
  localparam int PROD_W   = 2 * LANE_W;
  localparam int SUM_W    = PROD_W + $clog2(LANES) + 1;
  localparam int REG_IDX_W = 5;

  localparam logic [6:0] OPC_CUSTOM = 7'b0101011;
  localparam logic [2:0] F3_PDOT    = 3'b001;
  localparam logic [6:0] F7_PDOT    = 7'b0000000;

  // extreme lane products for signed LANE_W-bit operands
  localparam int PROD_MAX = 1 << (2 * LANE_W - 2);
  localparam int PROD_MIN = -((1 << (LANE_W - 1)) * ((1 << (LANE_W - 1)) - 1));
endpackage

// File: rtl/pdot_decode.sv
module pdot_decode
  import pdot_pkg::*;
#(
  parameter int IDX_W = REG_IDX_W
) (
  input  logic [6:0]       opcode,
  input  logic [2:0]       funct3,
  input  logic [6:0]       funct7,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             hit,
  output logic             wr_en
);
  logic rd_nonzero;

  always_comb begin
    hit        = (opcode == OPC_CUSTOM) && (funct3 == F3_PDOT) && (funct7 == F7_PDOT);
    rd_nonzero = |rd_idx;
    wr_en      = hit && rd_nonzero;
  end
endmodule

// File: rtl/pdot_lane_mul.sv
module pdot_lane_mul
  import pdot_pkg::*;
#(
  parameter int W = LANE_W,
  localparam int PW = 2 * W
) (
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  output logic signed [PW-1:0] p
);
  localparam int PMAX = 1 << (2 * W - 2);
  localparam int PMIN = -((1 << (W - 1)) * ((1 << (W - 1)) - 1));

  always_comb begin
    p = a * b;
  end

  always_comb begin
    // R4
    lane_range_chk: assert (int'(p) <= PMAX && int'(p) >= PMIN)
      else $error("lane product out of signed range");
    // R4
    lane_zero_chk: assert (!((a == '0) || (b == '0)) || (p == '0))
      else $error("lane product nonzero with zero operand");
  end
endmodule

// File: rtl/pdot_reduce.sv
module pdot_reduce
  import pdot_pkg::*;
#(
  parameter int N  = LANES,
  parameter int PW = PROD_W,
  parameter int SW = SUM_W
) (
  input  logic signed [PW-1:0] prods [N],
  output logic signed [SW-1:0] sum
);
  localparam int SMAX = N * (1 << (PW - 2));
  localparam int SMIN = -(N * ((1 << (PW / 2 - 1)) * ((1 << (PW / 2 - 1)) - 1)));

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) begin
      sum = sum + {{(SW - PW){prods[i][PW-1]}}, prods[i]};
    end
  end

  always_comb begin
    // R6
    sum_range_chk: assert (int'(sum) <= SMAX && int'(sum) >= SMIN)
      else $error("product sum outside reachable range");
  end
endmodule

// File: rtl/pdot_acc_unit.sv
module pdot_acc_unit
  import pdot_pkg::*;
#(
  parameter int XW  = XLEN,
  parameter int LW  = LANE_W,
  parameter int IW  = REG_IDX_W,
  localparam int NL = XW / LW,
  localparam int PW = 2 * LW,
  localparam int SW = PW + $clog2(NL) + 1
) (
  input  logic [6:0]    opcode,
  input  logic [2:0]    funct3,
  input  logic [6:0]    funct7,
  input  logic [IW-1:0] rd_idx,
  input  logic [XW-1:0] src_a,
  input  logic [XW-1:0] src_b,
  input  logic [XW-1:0] acc_in,
  output logic [XW-1:0] result,
  output logic          wr_en
);
  logic                 hit;
  logic signed [PW-1:0] prods [NL];
  logic signed [SW-1:0] dot_sum;
  logic        [XW-1:0] dot_ext;

  pdot_decode #(.IDX_W(IW)) u_dec (
    .opcode (opcode),
    .funct3 (funct3),
    .funct7 (funct7),
    .rd_idx (rd_idx),
    .hit    (hit),
    .wr_en  (wr_en)
  );

  for (genvar k = 0; k < NL; k++) begin : g_lane
    pdot_lane_mul #(.W(LW)) u_mul (
      .a (src_a[k*LW +: LW]),
      .b (src_b[k*LW +: LW]),
      .p (prods[k])
    );
  end

  pdot_reduce #(.N(NL), .PW(PW), .SW(SW)) u_red (
    .prods (prods),
    .sum   (dot_sum)
  );

  always_comb begin
    dot_ext = {{(XW - SW){dot_sum[SW-1]}}, dot_sum};
    result  = acc_in + dot_ext;
  end

  logic signed [XW-1:0] delta;
  always_comb begin
    delta = result - acc_in;
    // R8
    delta_sext_chk: assert ($signed(delta) <= NL * (1 << (PW - 2)) &&
                            $signed(delta) >= -(NL * ((1 << (LW - 1)) * ((1 << (LW - 1)) - 1))))
      else $error("accumulated delta not a sign-extended product sum");
    // R3
    rd_zero_chk: assert (!(wr_en && (rd_idx == '0)))
      else $error("write strobe raised for destination zero");
    // R2
    foreign_op_chk: assert (!(wr_en && !((opcode == OPC_CUSTOM) && (funct3 == F3_PDOT) && (funct7 == F7_PDOT))))
      else $error("write strobe raised for foreign encoding");
    // R1
    hit_strobe_chk: assert (!(hit && (rd_idx != '0)) || wr_en)
      else $error("matching encoding without write strobe");
  end
endmodule

// File: tb/tb_pdot_acc_unit.sv
module tb_pdot_acc_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic [6:0]  funct7;
  logic [4:0]  rd_idx;
  logic [31:0] src_a, src_b, acc_in;
  logic [31:0] result;
  logic        wr_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  pdot_acc_unit dut (
    .opcode (opcode), .funct3 (funct3), .funct7 (funct7), .rd_idx (rd_idx),
    .src_a (src_a), .src_b (src_b), .acc_in (acc_in),
    .result (result), .wr_en (wr_en)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c);
    int s = 0;
    for (int i = 0; i < 4; i++) begin
      logic signed [7:0] x = a[8*i +: 8];
      logic signed [7:0] y = b[8*i +: 8];
      s += int'(x) * int'(y);
    end
    return c + 32'(s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] op, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [4:0] rd, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c);
    @(negedge clk);
    opcode = op; funct3 = f3; funct7 = f7; rd_idx = rd;
    src_a = a; src_b = b; acc_in = c;
    @(posedge clk);
    #1;
  endtask

  task automatic t_idle();
    apply(7'h0, 3'h0, 7'h0, 5'd0, 32'h0, 32'h0, 32'h0);
    chk("R2 idle wr_en", {31'b0, wr_en}, 32'd0);
    chk("R5 idle result", result, 32'h0);
  endtask

  task automatic t_decode();
    apply(7'b0101011, 3'b001, 7'b0, 5'd7, 32'h01020304, 32'h01010101, 32'h10);
    chk("R1 match wr_en", {31'b0, wr_en}, 32'd1);
    chk("R1 match result", result, 32'h1A);
    apply(7'b0101011, 3'b001, 7'b0, 5'd31, 32'h0, 32'h0, 32'h0);
    chk("R1 rd31 wr_en", {31'b0, wr_en}, 32'd1);
    apply(7'b0101011, 3'b001, 7'b0, 5'd0, 32'h01020304, 32'h01010101, 32'h10);
    chk("R3 rd0 wr_en", {31'b0, wr_en}, 32'd0);
    for (int bitn = 0; bitn < 7; bitn++) begin
      apply(7'b0101011 ^ (7'd1 << bitn), 3'b001, 7'b0, 5'd3, 32'h0, 32'h0, 32'h0);
      chk("R2 opcode flip", {31'b0, wr_en}, 32'd0);
      apply(7'b0101011, 3'b001, 7'd1 << bitn, 5'd3, 32'h0, 32'h0, 32'h0);
      chk("R2 funct7 flip", {31'b0, wr_en}, 32'd0);
    end
    for (int bitn = 0; bitn < 3; bitn++) begin
      apply(7'b0101011, 3'b001 ^ (3'd1 << bitn), 7'b0, 5'd3, 32'h0, 32'h0, 32'h0);
      chk("R2 funct3 flip", {31'b0, wr_en}, 32'd0);
    end
  endtask

  task automatic t_lanes();
    for (int k = 0; k < 4; k++) begin
      apply(7'b0101011, 3'b001, 7'b0, 5'd1, 32'hFF << (8*k), 32'h03030303, 32'h0);
      chk("R4 single lane signed", result, 32'hFFFFFFFD);
      apply(7'b0101011, 3'b001, 7'b0, 5'd1, 32'h05 << (8*k), 32'h04 << (8*k), 32'h0);
      chk("R4 lane alignment", result, 32'd20);
    end
    apply(7'b0101011, 3'b001, 7'b0, 5'd1, 32'h000000FF, 32'h03000000, 32'h0);
    chk("R4 no cross-lane", result, 32'h0);
  endtask

  task automatic t_extreme();
    apply(7'b0101011, 3'b001, 7'b0, 5'd2, 32'h80808080, 32'h80808080, 32'h0);
    chk("R6 all -128 sum", result, 32'h00010000);
    apply(7'b0101011, 3'b001, 7'b0, 5'd2, 32'h80808080, 32'h80808080, 32'h12345678);
    chk("R6 all -128 plus acc", result, 32'h12355678);
  endtask

  task automatic t_wrap();
    apply(7'b0101011, 3'b001, 7'b0, 5'd4, 32'h80808080, 32'h80808080, 32'h7FFFFFFF);
    chk("R7 positive wrap", result, 32'h8000FFFF);
    apply(7'b0101011, 3'b001, 7'b0, 5'd4, 32'h7F7F7F7F, 32'h80808080, 32'h80000000);
    chk("R7 negative wrap", result, 32'h7FFF0200);
  endtask

  task automatic t_negative();
    apply(7'b0101011, 3'b001, 7'b0, 5'd5, 32'h7F7F7F7F, 32'h80808080, 32'h0);
    chk("R8 negative sext", result, 32'hFFFF0200);
    apply(7'b0101011, 3'b001, 7'b0, 5'd5, 32'h000000FF, 32'h00000001, 32'h00000100);
    chk("R8 small negative", result, 32'h000000FF);
  endtask

  task automatic t_random();
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic [31:0] c = $urandom;
      apply(7'b0101011, 3'b001, 7'b0, 5'd9, a, b, c);
      chk("R5 random vector", result, model(a, b, c));
    end
  endtask

  initial begin
    opcode = '0; funct3 = '0; funct7 = '0; rd_idx = '0;
    src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_decode();
    t_lanes();
    t_extreme();
    t_wrap();
    t_negative();
    t_random();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule